// File: doc/BRIEF.md
# Single-Wire Monitor Serial Port

This block is a half-duplex serial port on one shared data wire, meant for a debug or monitor link. It carries 8-bit NRZ mark/space frames in both directions at one common bit rate. The block has no internal baud generator: the bit period is the input clock divided by a ratio that is fixed once, when the port is switched on. The ratio comes from a strap input and a force-slow mode input. Both are sampled only at that entry event.

A start bit followed by nine more zero bit times, with no stop bit, is a break. When the port sees a break it takes over the wire. It drives the wire high for two bit times, then sends ten zero bit times back, then releases the wire. At all other times the wire is released, except while the port sends a byte.

Toward the core logic the port offers a transmit byte stream with valid/ready. On the receive side it gives one-cycle pulses for a good byte, a break and a framing error. The wire is split into a sampled input, a drive enable and a drive value, so an external pad or wired model resolves it.

Top module: `monport_top`

## Requirements
- R1: On the cycle where `enable` rises, the port latches the bit period. It is `DIV_HI` clocks when `rateSel` is 1 and `DIV_LO` clocks when `rateSel` is 0 (defaults 1024 and 512).
- R2: When `forceSlow` is 1 at entry, the bit period is `DIV_HI` regardless of `rateSel`.
- R3: Changes on `rateSel` or `forceSlow` after entry have no effect on timing until `enable` falls and rises again.
- R4: A byte accepted at a clock edge (`txValid` and `txReady` both 1) is driven starting in the next cycle. The frame is a 0 start bit, then data bit 0 first through bit 7, then a 1 stop bit, each lasting one bit period. The wire is released right after the stop bit.
- R5: With bit period D and H = D/2, a frame whose stop bit reads 1 gives a one-cycle `rxValid` pulse with the byte on `rxData`. The pulse comes H+9·D+2 clock edges after the first edge at which the wire is sampled low.
- R6: A frame whose eight data bits and stop bit all read 0 gives a one-cycle `breakDet` pulse at the R5 timing. From that cycle the port drives the wire high for 2·D cycles, then low for 10·D cycles, then releases it.
- R7: A frame whose stop bit reads 0 with any data bit 1 gives a one-cycle `framingErr` pulse at the R5 timing and no `rxValid`. The receiver then waits until the wire is high again before it accepts a new start bit.
- R8: A low pulse that has ended by the middle of the start bit is discarded. No receive pulse results and the port returns to idle.
- R9: While the port drives the wire (data frame or break response), its receiver is disabled. Its own output never produces `rxValid`, `breakDet` or `framingErr`.
- R10: `lineOe` is 0 whenever the port is not sending. This includes one cycle after `enable` falls, even in the middle of a frame.
- R11: `txReady` is 1 only while the port is enabled, idle and not seeing a start edge. When a start edge and a transmit request fall in the same cycle, the receive wins and the byte is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; bit periods are counted in its cycles |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Port on; its rising edge is the entry event |
| rateSel | input | 1 | Rate strap sampled at entry: 1 selects DIV_HI, 0 selects DIV_LO |
| forceSlow | input | 1 | Mode input sampled at entry: 1 forces DIV_HI |
| lineIn | input | 1 | Level of the shared wire (asynchronous, synchronised inside) |
| lineOe | output | 1 | 1 while the port drives the wire |
| lineOut | output | 1 | Value driven on the wire when lineOe is 1 |
| txData | input | 8 | Byte to send |
| txValid | input | 1 | Transmit request |
| txReady | output | 1 | Port can accept a byte this cycle |
| rxData | output | 8 | Last received byte |
| rxValid | output | 1 | One-cycle pulse: good byte received |
| breakDet | output | 1 | One-cycle pulse: break received, response starting |
| framingErr | output | 1 | One-cycle pulse: stop bit missing on a non-zero frame |

## Verification
Two things can land in the same cycle: the receiver seeing a falling start edge, and the core logic raising a transmit request. The bench provokes this by dropping the wire and asserting `txValid` exactly in the cycle where the synchronised edge first shows. It expects `txReady` to be 1 one cycle earlier and 0 in that cycle. No frame may appear on the wire, and the incoming byte must still arrive intact. A second overlap is the break pulse and the start of the high drive: both are expected in the same cycle, and they are judged against a per-cycle model of the wire.

// File: rtl/monport_pkg.sv
package monport_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RX_START,
    S_RX_DATA,
    S_RX_STOP,
    S_WAIT_HIGH,
    S_TX,
    S_BRK_HIGH,
    S_BRK_LOW
  } portState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       latchDiv;  // sample strap/mode into divisor
    logic       tmrHalf;   // start half-period count
    logic       tmrFull;   // start full-period count
    logic       bitLoad;   // load bit counter
    logic [3:0] bitInit;
    logic       bitDec;
    logic       rxShift;   // shift sampled bit into receive register
    logic       txLoad;    // load a frame into the send register
    logic       txShift;
    logic       drvEn;
    logic       drvHigh;
    logic       drvLow;
  } strobe_t;

endpackage

// File: rtl/monport_datapath.sv
module monport_datapath
  import monport_pkg::*;
#(
  parameter int DIV_HI = 1024,
  parameter int DIV_LO = 512
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    st,
  input  logic       rateSel,
  input  logic       forceSlow,
  input  logic       lineIn,
  input  logic [7:0] txByte,
  output logic       lineBit,
  output logic       startEdge,
  output logic       tick,
  output logic       bitZero,
  output logic       rxZero,
  output logic [7:0] rxByte,
  output logic       lineOe,
  output logic       lineOut
);

  localparam int DIV_W = $clog2(DIV_HI + 1);
  localparam int FRAME_BITS = 10;
  localparam int SYNC_DEPTH = 2;

  logic [SYNC_DEPTH-1:0] syncQ;
  logic                  lineQ;
  logic [DIV_W-1:0]      divReg;
  logic [DIV_W-1:0]      timer;
  logic [3:0]            bitCnt;
  logic [7:0]            rxReg;
  logic [FRAME_BITS-1:0] txReg;

  // wire synchroniser plus one stage of history for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '1;
      lineQ <= 1'b1;
    end else begin
      syncQ <= {syncQ[SYNC_DEPTH-2:0], lineIn};
      lineQ <= syncQ[SYNC_DEPTH-1];
    end
  end

  assign lineBit   = syncQ[SYNC_DEPTH-1];
  assign startEdge = lineQ & ~lineBit;

  // divisor, latched only at entry
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divReg <= DIV_W'(DIV_HI);
    end else if (st.latchDiv) begin
      divReg <= (forceSlow || rateSel) ? DIV_W'(DIV_HI) : DIV_W'(DIV_LO);
    end
  end

  // bit timer: reloads itself every period once started
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer <= '0;
    end else if (st.tmrHalf) begin
      timer <= (divReg >> 1) - DIV_W'(1);
    end else if (st.tmrFull || timer == '0) begin
      timer <= divReg - DIV_W'(1);
    end else begin
      timer <= timer - DIV_W'(1);
    end
  end

  assign tick = (timer == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (st.bitLoad) begin
      bitCnt <= st.bitInit;
    end else if (st.bitDec) begin
      bitCnt <= bitCnt - 4'd1;
    end
  end

  assign bitZero = (bitCnt == '0);

  // receive shift, least significant bit arrives first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxReg <= '0;
    end else if (st.rxShift) begin
      rxReg <= {lineBit, rxReg[7:1]};
    end
  end

  assign rxByte = rxReg;
  assign rxZero = (rxReg == '0);

  // send shift: start, data, stop; empties towards ones
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg <= '1;
    end else if (st.txLoad) begin
      txReg <= {1'b1, txByte, 1'b0};
    end else if (st.txShift) begin
      txReg <= {1'b1, txReg[FRAME_BITS-1:1]};
    end
  end

  assign lineOe  = st.drvEn;
  assign lineOut = ~st.drvEn | st.drvHigh | (~st.drvLow & txReg[0]);

endmodule

// File: rtl/monport_ctrl.sv
module monport_ctrl
  import monport_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    enable,
  input  logic    txValid,
  input  logic    lineBit,
  input  logic    startEdge,
  input  logic    tick,
  input  logic    bitZero,
  input  logic    rxZero,
  output strobe_t st,
  output logic    txReady,
  output logic    rxValid,
  output logic    breakDet,
  output logic    framingErr
);

  portState_e state, nxt;
  logic enableQ;
  logic active;
  logic rxValidN, breakN, frameErrN;

  assign active  = enable & enableQ;
  assign txReady = active & (state == S_IDLE) & ~startEdge;

  always_comb begin
    st          = '0;
    nxt         = state;
    rxValidN    = 1'b0;
    breakN      = 1'b0;
    frameErrN   = 1'b0;
    st.latchDiv = enable & ~enableQ;
    st.drvEn    = (state == S_TX) || (state == S_BRK_HIGH) || (state == S_BRK_LOW);
    st.drvHigh  = (state == S_BRK_HIGH);
    st.drvLow   = (state == S_BRK_LOW);
    if (!active) begin
      nxt = S_IDLE;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (startEdge) begin
            nxt        = S_RX_START;
            st.tmrHalf = 1'b1;
          end else if (txValid) begin
            nxt        = S_TX;
            st.txLoad  = 1'b1;
            st.tmrFull = 1'b1;
            st.bitLoad = 1'b1;
            st.bitInit = 4'd9;
          end
        end
        S_RX_START: if (tick) begin
          if (!lineBit) begin
            nxt        = S_RX_DATA;
            st.bitLoad = 1'b1;
            st.bitInit = 4'd7;
          end else begin
            nxt = S_IDLE;
          end
        end
        S_RX_DATA: if (tick) begin
          st.rxShift = 1'b1;
          if (bitZero) nxt = S_RX_STOP;
          else st.bitDec = 1'b1;
        end
        S_RX_STOP: if (tick) begin
          if (lineBit) begin
            nxt      = S_IDLE;
            rxValidN = 1'b1;
          end else if (rxZero) begin
            nxt        = S_BRK_HIGH;
            breakN     = 1'b1;
            st.bitLoad = 1'b1;
            st.bitInit = 4'd1;
          end else begin
            nxt       = S_WAIT_HIGH;
            frameErrN = 1'b1;
          end
        end
        S_WAIT_HIGH: if (lineBit) nxt = S_IDLE;
        S_TX: if (tick) begin
          st.txShift = 1'b1;
          if (bitZero) nxt = S_IDLE;
          else st.bitDec = 1'b1;
        end
        S_BRK_HIGH: if (tick) begin
          if (bitZero) begin
            nxt        = S_BRK_LOW;
            st.bitLoad = 1'b1;
            st.bitInit = 4'd9;
          end else begin
            st.bitDec = 1'b1;
          end
        end
        S_BRK_LOW: if (tick) begin
          if (bitZero) nxt = S_IDLE;
          else st.bitDec = 1'b1;
        end
        default: nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      enableQ    <= 1'b0;
      rxValid    <= 1'b0;
      breakDet   <= 1'b0;
      framingErr <= 1'b0;
    end else begin
      state      <= nxt;
      enableQ    <= enable;
      rxValid    <= rxValidN;
      breakDet   <= breakN;
      framingErr <= frameErrN;
    end
  end

endmodule

// File: rtl/monport_top.sv
module monport_top
  import monport_pkg::*;
#(
  parameter int DIV_HI = 1024,
  parameter int DIV_LO = 512
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       rateSel,
  input  logic       forceSlow,
  input  logic       lineIn,
  output logic       lineOe,
  output logic       lineOut,
  input  logic [7:0] txData,
  input  logic       txValid,
  output logic       txReady,
  output logic [7:0] rxData,
  output logic       rxValid,
  output logic       breakDet,
  output logic       framingErr
);

  strobe_t st;
  logic    lineBit, startEdge, tick, bitZero, rxZero;

  monport_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .txValid    (txValid),
    .lineBit    (lineBit),
    .startEdge  (startEdge),
    .tick       (tick),
    .bitZero    (bitZero),
    .rxZero     (rxZero),
    .st         (st),
    .txReady    (txReady),
    .rxValid    (rxValid),
    .breakDet   (breakDet),
    .framingErr (framingErr)
  );

  monport_datapath #(
    .DIV_HI (DIV_HI),
    .DIV_LO (DIV_LO)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .rateSel   (rateSel),
    .forceSlow (forceSlow),
    .lineIn    (lineIn),
    .txByte    (txData),
    .lineBit   (lineBit),
    .startEdge (startEdge),
    .tick      (tick),
    .bitZero   (bitZero),
    .rxZero    (rxZero),
    .rxByte    (rxData),
    .lineOe    (lineOe),
    .lineOut   (lineOut)
  );

endmodule

// File: rtl/monport_chk.sv
module monport_chk (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic lineOe,
  input logic lineOut,
  input logic txReady,
  input logic rxValid,
  input logic breakDet,
  input logic framingErr
);

  // R10: one cycle after disable the wire is released
  a_r10_release_on_disable: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !lineOe);

  // R11: no new byte is offered while the port is driving
  a_r11_no_ready_while_driving: assert property (@(posedge clk) disable iff (!rstN)
    lineOe |-> !txReady);

  // R9: the receiver stays silent while the port drives the wire
  a_r9_quiet_while_driving: assert property (@(posedge clk) disable iff (!rstN)
    lineOe |-> !(rxValid || framingErr));

  // R6: a detected break starts the high drive in the same cycle
  a_r6_break_starts_high: assert property (@(posedge clk) disable iff (!rstN)
    breakDet |-> (lineOe && lineOut));

  // R4: a data frame opens with a low start bit
  a_r4_frame_opens_low: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(lineOe) && !breakDet) |-> !lineOut);

  // R5: each received frame yields exactly one outcome
  a_r5_single_outcome: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rxValid, breakDet, framingErr}));

endmodule

bind monport_top monport_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .enable     (enable),
  .lineOe     (lineOe),
  .lineOut    (lineOut),
  .txReady    (txReady),
  .rxValid    (rxValid),
  .breakDet   (breakDet),
  .framingErr (framingErr)
);

// File: tb/tb_monport_top.sv
`timescale 1ns/1ps
module tb_monport_top;

  localparam int DHI = 16;
  localparam int DLO = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0, rateSel = 1'b0, forceSlow = 1'b0;
  logic hostLine = 1'b1;
  logic lineWire, lineOe, lineOut;
  logic [7:0] txData = '0;
  logic txValid = 1'b0, txReady;
  logic [7:0] rxData;
  logic rxValid, breakDet, framingErr;

  always #2.5 clk = ~clk;

  assign lineWire = lineOe ? lineOut : hostLine;

  monport_top #(.DIV_HI(DHI), .DIV_LO(DLO)) dut (
    .clk(clk), .rstN(rstN), .enable(enable), .rateSel(rateSel),
    .forceSlow(forceSlow), .lineIn(lineWire), .lineOe(lineOe),
    .lineOut(lineOut), .txData(txData), .txValid(txValid),
    .txReady(txReady), .rxData(rxData), .rxValid(rxValid),
    .breakDet(breakDet), .framingErr(framingErr)
  );

  typedef struct { int from; int upto; logic val; string tag; } seg_t;
  typedef struct { int at; int kind; logic [7:0] data; } evt_t;

  seg_t segs[$];
  evt_t evts[$];
  int cyc = 0;
  int total = 0, bad = 0;
  int modelDiv = DHI;
  int evtCount = 0;
  bit modelOn = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s cyc=%0d actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  // per-cycle reference: wire drive and receive pulses
  always @(negedge clk) begin
    if (modelOn) begin
      logic expOe, expOut;
      string tag;
      bit eRx, eBrk, eFe;
      logic [7:0] eData;
      expOe = 1'b0; expOut = 1'b1; tag = "R10";
      foreach (segs[i]) if (cyc >= segs[i].from && cyc < segs[i].upto) begin
        expOe = 1'b1; expOut = segs[i].val; tag = segs[i].tag;
      end
      check(lineOe === expOe && (!expOe || lineOut === expOut), tag,
            {lineOe, lineOut}, {expOe, expOut});
      eRx = 0; eBrk = 0; eFe = 0; eData = '0;
      foreach (evts[i]) if (evts[i].at == cyc) begin
        if (evts[i].kind == 0) begin eRx = 1; eData = evts[i].data; end
        if (evts[i].kind == 1) eBrk = 1;
        if (evts[i].kind == 2) eFe = 1;
      end
      check(rxValid === eRx && (!eRx || rxData === eData), "R5",
            {rxValid, rxData}, {eRx, eData});
      check(breakDet === eBrk, "R6", breakDet, eBrk);
      check(framingErr === eFe, "R7", framingErr, eFe);
      if (rxValid || breakDet || framingErr) evtCount++;
    end
  end

  task automatic enter(input logic rs, input logic fs);
    enable = 1'b0;
    repeat (3) @(negedge clk);
    rateSel = rs; forceSlow = fs; enable = 1'b1;
    modelDiv = (rs || fs) ? DHI : DLO;
    repeat (3) @(negedge clk);
  endtask

  task automatic sendByte(input logic [7:0] d, input string tag);
    int c;
    logic [9:0] fr;
    while (!txReady) @(negedge clk);
    txData = d; txValid = 1'b1; c = cyc; fr = {1'b1, d, 1'b0};
    for (int i = 0; i < 10; i++)
      segs.push_back('{c + 1 + i * modelDiv, c + 1 + (i + 1) * modelDiv, fr[i], tag});
    @(negedge clk);
    txValid = 1'b0;
  endtask

  task automatic hostSend(input logic [7:0] d, input logic stopBit, input int extraLow);
    int c0, at;
    c0 = cyc;
    at = c0 + modelDiv / 2 + 3 + 9 * modelDiv;
    if (stopBit) evts.push_back('{at, 0, d});
    else if (d == 8'h00) begin
      evts.push_back('{at, 1, d});
      segs.push_back('{at, at + 2 * modelDiv, 1'b1, "R6"});
      segs.push_back('{at + 2 * modelDiv, at + 12 * modelDiv, 1'b0, "R6"});
    end else evts.push_back('{at, 2, d});
    hostLine = 1'b0;
    repeat (modelDiv) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      hostLine = d[i];
      repeat (modelDiv) @(negedge clk);
    end
    hostLine = stopBit;
    repeat (modelDiv) @(negedge clk);
    if (!stopBit) repeat (extraLow) @(negedge clk);
    hostLine = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int snap, brkEnd;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    modelOn = 1;
    @(negedge clk);
    check(lineOe === 1'b0, "R10", lineOe, 0);
    check(txReady === 1'b0, "R11", txReady, 0);

    // strap high: slow rate
    enter(1'b1, 1'b0);
    check(txReady === 1'b1, "R11", txReady, 1);
    snap = evtCount;
    sendByte(8'hA5, "R1");
    repeat (3) @(negedge clk);
    check(txReady === 1'b0, "R11", txReady, 0);
    repeat (10 * modelDiv + 2) @(negedge clk);
    check(evtCount == snap, "R9", evtCount, snap);

    // plain receive
    hostSend(8'h3C, 1'b1, 0);
    repeat (2 * modelDiv) @(negedge clk);

    // start edge and transmit request in the same cycle
    snap = evtCount;
    fork
      hostSend(8'hC6, 1'b1, 0);
      begin
        @(negedge clk);
        check(txReady === 1'b1, "R11", txReady, 1);
        @(negedge clk);
        check(txReady === 1'b0, "R11", txReady, 0);
        txData = 8'hFF; txValid = 1'b1;
        @(negedge clk);
        txValid = 1'b0;
      end
    join
    repeat (2 * modelDiv) @(negedge clk);
    check(evtCount == snap + 1, "R11", evtCount, snap + 1);

    // break and its response
    snap = cyc;
    hostSend(8'h00, 1'b0, 0);
    brkEnd = snap + modelDiv / 2 + 3 + 21 * modelDiv;
    check(txReady === 1'b0, "R11", txReady, 0);
    while (cyc < brkEnd + 3) @(negedge clk);
    check(txReady === 1'b1, "R6", txReady, 1);

    // framing error, wire held low afterwards
    fork
      hostSend(8'hA5, 1'b0, 3 * modelDiv);
      begin
        repeat (11 * modelDiv) @(negedge clk);
        check(txReady === 1'b0, "R7", txReady, 0);
      end
    join
    repeat (4) @(negedge clk);
    check(txReady === 1'b1, "R7", txReady, 1);

    // short low glitch
    snap = evtCount;
    hostLine = 1'b0;
    repeat (2) @(negedge clk);
    hostLine = 1'b1;
    repeat (2 * modelDiv) @(negedge clk);
    check(evtCount == snap, "R8", evtCount, snap);
    check(txReady === 1'b1, "R8", txReady, 1);

    // strap low: fast rate; later strap change ignored
    enter(1'b0, 1'b0);
    sendByte(8'h5A, "R1");
    repeat (10 * modelDiv + 2) @(negedge clk);
    rateSel = 1'b1;
    sendByte(8'h0F, "R3");
    repeat (10 * modelDiv + 2) @(negedge clk);
    hostSend(8'hC3, 1'b1, 0);
    repeat (2 * modelDiv) @(negedge clk);

    // force mode overrides strap
    enter(1'b0, 1'b1);
    sendByte(8'h81, "R2");
    repeat (10 * modelDiv + 2) @(negedge clk);

    // disable in the middle of a frame
    sendByte(8'h77, "R4");
    repeat (3 * modelDiv) @(negedge clk);
    enable = 1'b0;
    foreach (segs[i]) if (segs[i].upto > cyc + 1) segs[i].upto = cyc + 1;
    @(negedge clk);
    check(lineOe === 1'b0, "R10", lineOe, 0);
    check(txReady === 1'b0, "R11", txReady, 0);
    repeat (20) @(negedge clk);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule